// File: doc/BRIEF.md
# Dual Multiply-Rotate-Subtract Random Generator

This block produces 64-bit pseudo-random words from two independent sub-generators. Every step of a sub-generator keeps a copy of its state, multiplies the state by a fixed odd constant, rotates the product left by a fixed amount, and subtracts the saved copy. All arithmetic wraps modulo 2^64. Because of the subtraction, a step cannot be undone. The word the block emits is the wrapping sum of the two new states. The combined period is roughly 2^72.66.

Software or a control block starts the generator by pulsing a load strobe with a 32-bit seed. Loading puts both states back to fixed start values. Each sub-generator then counts down its own seed-selected number of warm-up steps, and a busy flag stays high until both have finished. After that, each clock in which the step enable is high produces one new word. The word appears one cycle later, marked by a valid pulse. A new load is accepted at any time and begins the whole sequence again.

Top module: `dual_cmrs_rng`

## Requirements
- R1: A synchronous reset leaves busy low and the valid flag low.
- R2: A load strobe is sampled at a clock edge. It raises busy for exactly max(seed[15:0], seed[31:16]) + 10 cycles, counted from that edge.
- R3: Lane A starts from 138563767 and takes seed[15:0] + 10 warm-up steps with multiplier 3188803096312630803 and rotate 33. Lane B starts from 2400589211 and takes seed[31:16] + 10 warm-up steps with multiplier 14882990517504201107 and rotate 30. One step is x' = rotl(M*x, R) - x.
- R4: While busy is high, step enable has no effect and valid stays low. The first word after warm-up is the sum of the states after exactly one step beyond warm-up.
- R5: When busy is low and step enable is high at an edge, both lanes step at that edge. At the same edge the output register loads the modulo-2^64 sum of the two new states, and valid goes high.
- R6: When step enable is low, valid is low at the next edge and the output word keeps its value.
- R7: A load while the generator is producing words discards the old states and restarts from the start values.
- R8: A load while warm-up is in progress restarts the warm-up using the new seed.
- R9: A load takes priority over step enable in the same cycle: no word is produced at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load strobe: start a new seeding |
| seed | input | 32 | Seed; low half sets lane A warm-up, high half sets lane B warm-up |
| step_en | input | 1 | Request one output word this cycle |
| busy | output | 1 | Warm-up in progress |
| rnd_out | output | 64 | Latest random word |
| rnd_valid | output | 1 | rnd_out was updated at the last edge |

## Verification
The bench sweeps both seed halves over a small grid and compares every word with a model computed in the bench. A design that stepped both lanes the same number of times, or swapped which half goes to which lane, would give wrong words for the asymmetric seeds. A design that ends busy after the shorter count, or a cycle early or late, fails the exact busy-length check; one seed has a maximal high half to test the counter width. The bench holds step enable high through warm-up to catch a lane that advances during warm-up. It issues loads in the middle of warm-up, in the middle of output, and together with step enable, to catch a design that keeps stale state or emits a word on a load edge.

// File: rtl/cmrs_pkg.sv
package cmrs_pkg;
   localparam int unsigned NUM_LANES = 2;
   localparam int unsigned WORD_W    = 64;

   typedef logic [WORD_W-1:0] word_t;

   function automatic word_t lane_mult(input int unsigned idx);
      return (idx == 0) ? 64'd3188803096312630803 : 64'd14882990517504201107;
   endfunction

   function automatic int unsigned lane_rot(input int unsigned idx);
      return (idx == 0) ? 33 : 30;
   endfunction

   function automatic word_t lane_init(input int unsigned idx);
      return (idx == 0) ? 64'd138563767 : 64'd2400589211;
   endfunction
endpackage

// File: rtl/cmrs_step.sv
module cmrs_step #(
   parameter int unsigned       WIDTH = 64,
   parameter logic [WIDTH-1:0]  MULT  = '1,
   parameter int unsigned       ROT   = 1
) (
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] nxt
);
   logic [WIDTH-1:0] prod;
   logic [WIDTH-1:0] rot;

   if (ROT >= WIDTH) begin : g_bad_rot
      $error("cmrs_step: ROT must be below WIDTH");
   end

   assign prod = cur * MULT;

   if (ROT == 0) begin : g_norot
      assign rot = prod;
   end else begin : g_rot
      assign rot = {prod[WIDTH-ROT-1:0], prod[WIDTH-1:WIDTH-ROT]};
   end

   assign nxt = rot - cur;
endmodule

// File: rtl/cmrs_lane.sv
module cmrs_lane #(
   parameter int unsigned       WIDTH  = 64,
   parameter int unsigned       HALF_W = 16,
   parameter int unsigned       EXTRA  = 10,
   parameter logic [WIDTH-1:0]  MULT   = '1,
   parameter int unsigned       ROT    = 1,
   parameter logic [WIDTH-1:0]  INIT   = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [HALF_W-1:0] half,
   input  logic              advance,
   output logic              warming,
   output logic [WIDTH-1:0]  nxt_state
);
   localparam int unsigned CNT_W = HALF_W + 1;

   if (EXTRA >= (1 << HALF_W)) begin : g_bad_extra
      $error("cmrs_lane: EXTRA too large for counter");
   end

   logic [WIDTH-1:0] state_q;
   logic [CNT_W-1:0] cnt_q;

   cmrs_step #(.WIDTH(WIDTH), .MULT(MULT), .ROT(ROT)) u_step (
      .cur(state_q),
      .nxt(nxt_state)
   );

   assign warming = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= INIT;
         cnt_q   <= '0;
      end else if (load) begin
         state_q <= INIT;
         cnt_q   <= {1'b0, half} + CNT_W'(EXTRA);
      end else if (warming) begin
         state_q <= nxt_state;
         cnt_q   <= cnt_q - CNT_W'(1);
      end else if (advance) begin
         state_q <= nxt_state;
      end
   end
endmodule

// File: rtl/cmrs_sum.sv
module cmrs_sum #(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   fire,
   input  logic [LANES*WIDTH-1:0] lane_words,
   output logic [WIDTH-1:0]       word_q,
   output logic                   valid_q
);
   logic [WIDTH-1:0] total;

   always_comb begin
      total = '0;
      for (int i = 0; i < LANES; i++) begin
         total = total + lane_words[i*WIDTH +: WIDTH];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= fire;
         if (fire) word_q <= total;
      end
   end
endmodule

// File: rtl/dual_cmrs_rng.sv
module dual_cmrs_rng #(
   parameter int unsigned WIDTH      = 64,
   parameter int unsigned SEED_W     = 32,
   parameter int unsigned WARM_EXTRA = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              seed_load,
   input  logic [SEED_W-1:0] seed,
   input  logic              step_en,
   output logic              busy,
   output logic [WIDTH-1:0]  rnd_out,
   output logic              rnd_valid
);
   import cmrs_pkg::*;

   localparam int unsigned LANES  = NUM_LANES;
   localparam int unsigned HALF_W = SEED_W / LANES;

   if (WIDTH > WORD_W || WIDTH < 32) begin : g_bad_width
      $error("dual_cmrs_rng: WIDTH out of range");
   end
   if (SEED_W % LANES != 0) begin : g_bad_seed
      $error("dual_cmrs_rng: SEED_W must split evenly across lanes");
   end

   logic [LANES-1:0]       lane_warm;
   logic [LANES*WIDTH-1:0] lane_next;
   logic                   advance;

   assign busy    = |lane_warm;
   assign advance = step_en & ~busy & ~seed_load;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam word_t M64 = lane_mult(g);
      localparam word_t I64 = lane_init(g);
      cmrs_lane #(
         .WIDTH (WIDTH),
         .HALF_W(HALF_W),
         .EXTRA (WARM_EXTRA),
         .MULT  (M64[WIDTH-1:0]),
         .ROT   (lane_rot(g)),
         .INIT  (I64[WIDTH-1:0])
      ) u_lane (
         .clk      (clk),
         .rst      (rst),
         .load     (seed_load),
         .half     (seed[g*HALF_W +: HALF_W]),
         .advance  (advance),
         .warming  (lane_warm[g]),
         .nxt_state(lane_next[g*WIDTH +: WIDTH])
      );
   end

   cmrs_sum #(.WIDTH(WIDTH), .LANES(LANES)) u_sum (
      .clk       (clk),
      .rst       (rst),
      .fire      (advance),
      .lane_words(lane_next),
      .word_q    (rnd_out),
      .valid_q   (rnd_valid)
   );
endmodule

// File: rtl/cmrs_chk.sv
module cmrs_chk #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned SEED_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              seed_load,
   input logic [SEED_W-1:0] seed,
   input logic              step_en,
   input logic              busy,
   input logic [WIDTH-1:0]  rnd_out,
   input logic              rnd_valid
);
   AST_LOAD_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
      seed_load |=> busy); // R2
   AST_NO_WORD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |=> !rnd_valid); // R4
   AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> !rnd_valid); // R6
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(rnd_out)); // R6
   AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (rst)
      (seed_load && step_en) |=> !rnd_valid); // R9
   AST_SEED_KNOWN: assert property (@(posedge clk) disable iff (rst)
      seed_load |-> !$isunknown(seed)); // R2
endmodule

bind dual_cmrs_rng cmrs_chk #(.WIDTH(WIDTH), .SEED_W(SEED_W)) u_chk (.*);

// File: tb/tb_dual_cmrs_rng.sv
`timescale 1ns/1ps
module tb_dual_cmrs_rng;
   logic        clk = 0;
   logic        rst = 1;
   logic        seed_load = 0;
   logic [31:0] seed = '0;
   logic        step_en = 0;
   logic        busy;
   logic [63:0] rnd_out;
   logic        rnd_valid;

   int total = 0;
   int bad = 0;
   logic [63:0] mx, my, last_out;

   always #2.5 clk = ~clk;

   dual_cmrs_rng dut (.*);

   function automatic logic [63:0] stp(input logic [63:0] x, input logic [63:0] m,
                                       input int r);
      logic [63:0] p;
      p = x * m;
      return ((p << r) | (p >> (64 - r))) - x;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_seed(input logic [31:0] s);
      mx = 64'd138563767;
      my = 64'd2400589211;
      for (int i = 0; i < int'(s[15:0]) + 10; i++) mx = stp(mx, 64'd3188803096312630803, 33);
      for (int i = 0; i < int'(s[31:16]) + 10; i++) my = stp(my, 64'd14882990517504201107, 30);
   endtask

   // load; step_en held at 'hold' during the load cycle and after
   task automatic do_load(input logic [31:0] s, input bit hold);
      @(negedge clk);
      seed_load = 1; seed = s; step_en = hold;
      @(posedge clk); #1;
      chk(busy == 1'b1, "R2 busy after load", 64'(busy), 64'd1);
      chk(rnd_valid == 1'b0, "R9 no word on load edge", 64'(rnd_valid), 64'd0);
      @(negedge clk);
      seed_load = 0;
      model_seed(s);
   endtask

   // count busy cycles: one already elapsed after the load edge
   task automatic wait_warm(input logic [31:0] s);
      int k, n;
      bit vbad;
      k = 1; vbad = 0;
      n = ((s[15:0] > s[31:16]) ? int'(s[15:0]) : int'(s[31:16])) + 10;
      while (busy) begin
         @(posedge clk); #1;
         if (rnd_valid) vbad = 1;
         if (busy) k++;
      end
      chk(k == n, "R2 busy length", 64'(k), 64'(n));
      chk(!vbad, "R4 no valid during warm-up", 64'(vbad), 64'd0);
   endtask

   task automatic run_steps(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); step_en = 1;
         @(posedge clk); #1;
         mx = stp(mx, 64'd3188803096312630803, 33);
         my = stp(my, 64'd14882990517504201107, 30);
         chk(rnd_valid == 1'b1, req, 64'(rnd_valid), 64'd1);
         chk(rnd_out == mx + my, req, rnd_out, mx + my);
      end
      last_out = mx + my;
   endtask

   task automatic idle_check;
      @(negedge clk); step_en = 0;
      @(posedge clk); #1;
      chk(rnd_valid == 1'b0, "R6 valid low when idle", 64'(rnd_valid), 64'd0);
      @(posedge clk); #1;
      chk(rnd_out == last_out, "R6 word held", rnd_out, last_out);
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
      chk(rnd_valid == 1'b0, "R1 valid after reset", 64'(rnd_valid), 64'd0);
      @(negedge clk); rst = 0;

      // R3 R5: sweep both seed halves on a small grid
      for (int lo = 0; lo < 4; lo++) begin
         for (int hi = 0; hi < 4; hi++) begin
            do_load({16'(hi * 3), 16'(lo * 5)}, 1'b0);
            wait_warm({16'(hi * 3), 16'(lo * 5)});
            run_steps(3, "R3 R5 word after seed");
         end
      end
      idle_check();

      // R4: step enable held high through warm-up
      do_load(32'h0007_0002, 1'b1);
      wait_warm(32'h0007_0002);
      run_steps(4, "R4 first words after held enable");
      idle_check();

      // R7: load while producing words
      run_steps(2, "R5 before restart");
      do_load(32'h0001_0009, 1'b1);
      wait_warm(32'h0001_0009);
      run_steps(3, "R7 words after restart");

      // R8: load during warm-up
      do_load(32'h0020_0030, 1'b0);
      repeat (5) @(negedge clk);
      do_load(32'h0004_0006, 1'b0);
      wait_warm(32'h0004_0006);
      run_steps(3, "R8 words after warm-up restart");
      idle_check();

      // R2: maximal high half
      do_load(32'hFFFF_0000, 1'b0);
      wait_warm(32'hFFFF_0000);
      run_steps(2, "R3 words after long warm-up");
      idle_check();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule